// File: doc/BRIEF.md
# Inverted Microword Control Store Loader

This block sits between an 8-bit I/O processor bus and the writable control store and task program counter (TPC) table of a microcoded central processor. The I/O processor sees an eight-port window selected by a 3-bit port select. Six ports stage one 48-bit microinstruction, most significant byte first. The remaining two ports build a 12-bit TPC entry together with its 3-bit task address. Every byte the I/O processor writes is the bitwise complement of the value it means, so the loader inverts each byte on capture.

A write to the least significant microword port commits the staged word. The block then emits a one-cycle control-store write strobe, with the address taken from a separate address input. A write to the TPC-low port commits a TPC entry built from that byte and the most recent TPC-high byte. Reads through the same window return the staged bytes in the same inverted form in which they were written.

Top module: `cs_loader`

## Requirements
- R1: While rst_ni is low and on the first cycle after reset, cs_we_o, tpc_we_o, cs_addr_o, cs_wdata_o, tpc_addr_o, tpc_wdata_o and bus_rdata_o are all zero. All staged bytes clear to zero, so a read of ports 0 to 6 returns 8'hFF and a read of port 7 returns 8'h7F.
- R2: A write to port k (k = 0..5) stores the complement of bus_wdata_i as microword bits [47-8k : 40-8k]. Port 0 holds the most significant byte.
- R3: cs_we_o is high for exactly the one cycle after each write to port 5. Writes to ports 0 to 4, writes to ports 6 and 7, and reads never raise it.
- R4: On a commit, cs_addr_o equals cs_addr_i as sampled with the port-5 write. cs_wdata_o equals the full word, including the complement of the byte written to port 5.
- R5: A commit uses the latest stored value of ports 0 to 4, even when those were written before an earlier commit.
- R6: A write to port 6 (TPC high) stores its complement. Complemented bits [7:5] are the TPC address, most significant first. Complemented bits [4:0] are TPC data bits [11:7]. This write alone never raises tpc_we_o.
- R7: tpc_we_o is high for exactly the one cycle after each write to port 7 (TPC low). tpc_wdata_o[6:0] is the complement of bits [6:0] of that byte, and its bit 7 has no effect on any output.
- R8: A TPC commit takes its address and upper data bits from the most recently written TPC-high byte, so repeated TPC-low writes reuse it.
- R9: With bus_rd_i high, bus_rdata_o on the next cycle equals the complement of the stored byte for the selected port. For port 7 it is {1'b0, complement of the stored 7 bits}. In a cycle that follows no read, bus_rdata_o is zero.
- R10: Reads change no staged state and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | I/O processor write strobe |
| bus_rd_i | input | 1 | I/O processor read strobe |
| bus_sel_i | input | 3 | Port select within the window |
| bus_wdata_i | input | 8 | Write byte (inverted convention) |
| bus_rdata_o | output | 8 | Read byte, registered |
| cs_addr_i | input | CS_AW | Control-store target address |
| cs_we_o | output | 1 | Control-store write strobe |
| cs_addr_o | output | CS_AW | Control-store write address |
| cs_wdata_o | output | 48 | Control-store write data |
| tpc_we_o | output | 1 | TPC write strobe |
| tpc_addr_o | output | 3 | TPC entry address |
| tpc_wdata_o | output | 12 | TPC entry data |

## Verification
The bench loads microwords whose byte values separate every byte lane. A design that missed the inversion, reversed the byte order or shifted a lane would commit a visibly different word. It then rewrites only port 5 to confirm that earlier bytes persist and the new address is taken; a design that cleared the stage on commit would emit zeros in the upper bytes. For the TPC path it flips the ignored bit 7 of the low byte, commits twice from a single high byte, and writes the high byte alone, which catches a leaking bit 7, a high byte consumed by its first use, and a strobe fired on the wrong port. Reads are interleaved with strobe checks, so a read path that disturbed the stage or pulsed a write shows up.

// File: rtl/csl_pkg.sv
package csl_pkg;
  localparam int BYTE_W      = 8;
  localparam int UWORD_BYTES = 6;
  localparam int UWORD_W     = UWORD_BYTES * BYTE_W;
  localparam int N_PORTS     = 8;
  localparam int SEL_W       = $clog2(N_PORTS);
  localparam int TPC_AW      = 3;
  localparam int TPC_DW      = 12;
  localparam int TPC_HI_DW   = BYTE_W - TPC_AW;
  localparam int TPC_LO_DW   = TPC_DW - TPC_HI_DW;
  localparam int UW_LAST     = UWORD_BYTES - 1;
  localparam int SEL_TPC_HI  = UWORD_BYTES;
  localparam int SEL_TPC_LO  = UWORD_BYTES + 1;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic [UWORD_BYTES-1:0] uw_wr;
    logic                   hi_wr;
    logic                   lo_wr;
  } wr_dec_t;

  // Low bit of the lane that holds byte k (k=0 is most significant).
  function automatic int lane_lsb(input int k);
    return UWORD_W - BYTE_W * (k + 1);
  endfunction
endpackage

// File: rtl/csl_port_decode.sv
module csl_port_decode
  import csl_pkg::*;
(
  input  logic             bus_wr_i,
  input  logic [SEL_W-1:0] bus_sel_i,
  output wr_dec_t          dec_o
);
  always_comb begin
    dec_o = '0;
    if (bus_wr_i) begin
      for (int k = 0; k < UWORD_BYTES; k++) begin
        if (bus_sel_i == SEL_W'(k)) dec_o.uw_wr[k] = 1'b1;
      end
      if (bus_sel_i == SEL_W'(SEL_TPC_HI)) dec_o.hi_wr = 1'b1;
      if (bus_sel_i == SEL_W'(SEL_TPC_LO)) dec_o.lo_wr = 1'b1;
    end
  end
endmodule

// File: rtl/csl_uword_stage.sv
module csl_uword_stage
  import csl_pkg::*;
#(
  parameter int CS_AW = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [UWORD_BYTES-1:0] uw_wr_i,
  input  byte_t                  wdata_i,
  input  logic [CS_AW-1:0]       cs_addr_i,
  output logic [UWORD_W-1:0]     stage_o,
  output logic                   cs_we_o,
  output logic [CS_AW-1:0]       cs_addr_o,
  output logic [UWORD_W-1:0]     cs_wdata_o
);
  logic [UWORD_W-1:0] next_word;

  for (genvar k = 0; k < UWORD_BYTES; k++) begin : g_lane
    localparam int LSB = lane_lsb(k);
    byte_t lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        lane_q <= '0;
      else if (uw_wr_i[k]) lane_q <= ~wdata_i;
    end

    assign stage_o[LSB +: BYTE_W]   = lane_q;
    assign next_word[LSB +: BYTE_W] = uw_wr_i[k] ? ~wdata_i : lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_we_o    <= 1'b0;
      cs_addr_o  <= '0;
      cs_wdata_o <= '0;
    end else begin
      cs_we_o <= uw_wr_i[UW_LAST];
      if (uw_wr_i[UW_LAST]) begin
        cs_addr_o  <= cs_addr_i;
        cs_wdata_o <= next_word;
      end
    end
  end
endmodule

// File: rtl/csl_tpc_stage.sv
module csl_tpc_stage
  import csl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hi_wr_i,
  input  logic                 lo_wr_i,
  input  byte_t                wdata_i,
  output byte_t                hi_o,
  output logic [TPC_LO_DW-1:0] lo_o,
  output logic                 tpc_we_o,
  output logic [TPC_AW-1:0]    tpc_addr_o,
  output logic [TPC_DW-1:0]    tpc_wdata_o
);
  byte_t                hi_q;
  logic [TPC_LO_DW-1:0] lo_q;
  logic [TPC_LO_DW-1:0] lo_true;

  assign lo_true = ~wdata_i[TPC_LO_DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_wr_i) hi_q <= ~wdata_i;
      if (lo_wr_i) lo_q <= lo_true;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpc_we_o    <= 1'b0;
      tpc_addr_o  <= '0;
      tpc_wdata_o <= '0;
    end else begin
      tpc_we_o <= lo_wr_i;
      if (lo_wr_i) begin
        tpc_addr_o  <= hi_q[BYTE_W-1 -: TPC_AW];
        tpc_wdata_o <= {hi_q[TPC_HI_DW-1:0], lo_true};
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/cs_loader.sv
module cs_loader
  import csl_pkg::*;
#(
  parameter int CS_AW = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_wr_i,
  input  logic                  bus_rd_i,
  input  logic [SEL_W-1:0]      bus_sel_i,
  input  logic [BYTE_W-1:0]     bus_wdata_i,
  output logic [BYTE_W-1:0]     bus_rdata_o,
  input  logic [CS_AW-1:0]      cs_addr_i,
  output logic                  cs_we_o,
  output logic [CS_AW-1:0]      cs_addr_o,
  output logic [UWORD_W-1:0]    cs_wdata_o,
  output logic                  tpc_we_o,
  output logic [TPC_AW-1:0]     tpc_addr_o,
  output logic [TPC_DW-1:0]     tpc_wdata_o
);
  wr_dec_t              dec;
  logic [UWORD_W-1:0]   stage;
  byte_t                tpc_hi;
  logic [TPC_LO_DW-1:0] tpc_lo;
  byte_t                rd_mux;

  csl_port_decode u_dec (
    .bus_wr_i (bus_wr_i),
    .bus_sel_i(bus_sel_i),
    .dec_o    (dec)
  );

  csl_uword_stage #(.CS_AW(CS_AW)) u_uw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .uw_wr_i   (dec.uw_wr),
    .wdata_i   (bus_wdata_i),
    .cs_addr_i (cs_addr_i),
    .stage_o   (stage),
    .cs_we_o   (cs_we_o),
    .cs_addr_o (cs_addr_o),
    .cs_wdata_o(cs_wdata_o)
  );

  csl_tpc_stage u_tpc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hi_wr_i    (dec.hi_wr),
    .lo_wr_i    (dec.lo_wr),
    .wdata_i    (bus_wdata_i),
    .hi_o       (tpc_hi),
    .lo_o       (tpc_lo),
    .tpc_we_o   (tpc_we_o),
    .tpc_addr_o (tpc_addr_o),
    .tpc_wdata_o(tpc_wdata_o)
  );

  // Read-back returns the bus convention (complemented).
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < UWORD_BYTES; k++) begin
      if (bus_sel_i == SEL_W'(k)) rd_mux = ~stage[lane_lsb(k) +: BYTE_W];
    end
    if (bus_sel_i == SEL_W'(SEL_TPC_HI)) rd_mux = ~tpc_hi;
    if (bus_sel_i == SEL_W'(SEL_TPC_LO)) rd_mux = {{(BYTE_W-TPC_LO_DW){1'b0}}, ~tpc_lo};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
    else               bus_rdata_o <= '0;
  end
endmodule

// File: rtl/cs_loader_chk.sv
module cs_loader_chk
  import csl_pkg::*;
#(
  parameter int CS_AW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_wr_i,
  input logic                 bus_rd_i,
  input logic [SEL_W-1:0]     bus_sel_i,
  input logic [BYTE_W-1:0]    bus_wdata_i,
  input logic [BYTE_W-1:0]    bus_rdata_o,
  input logic [CS_AW-1:0]     cs_addr_i,
  input logic                 cs_we_o,
  input logic [CS_AW-1:0]     cs_addr_o,
  input logic [UWORD_W-1:0]   cs_wdata_o,
  input logic                 tpc_we_o,
  input logic [TPC_AW-1:0]    tpc_addr_o,
  input logic [TPC_DW-1:0]    tpc_wdata_o
);
  a_r3_cs_we_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_o |-> $past(bus_wr_i && bus_sel_i == SEL_W'(UW_LAST)));

  a_r3_cs_we_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_sel_i == SEL_W'(UW_LAST)) |=> cs_we_o);

  a_r4_cs_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_o |-> cs_addr_o == $past(cs_addr_i));

  a_r4_cs_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_we_o |-> cs_wdata_o[BYTE_W-1:0] == ~$past(bus_wdata_i));

  a_r7_tpc_we_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpc_we_o |-> $past(bus_wr_i && bus_sel_i == SEL_W'(SEL_TPC_LO)));

  a_r7_tpc_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tpc_we_o |-> tpc_wdata_o[TPC_LO_DW-1:0] == ~$past(bus_wdata_i[TPC_LO_DW-1:0]));

  a_r9_idle_rdata: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_rd_i) |-> bus_rdata_o == '0);

  a_r10_read_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && !bus_wr_i) |=> (!cs_we_o && !tpc_we_o));
endmodule

bind cs_loader cs_loader_chk #(.CS_AW(CS_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .bus_rd_i   (bus_rd_i),
  .bus_sel_i  (bus_sel_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .cs_addr_i  (cs_addr_i),
  .cs_we_o    (cs_we_o),
  .cs_addr_o  (cs_addr_o),
  .cs_wdata_o (cs_wdata_o),
  .tpc_we_o   (tpc_we_o),
  .tpc_addr_o (tpc_addr_o),
  .tpc_wdata_o(tpc_wdata_o)
);

// File: tb/cs_loader_bench.sv
module cs_loader_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [2:0]  bus_sel_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic [11:0] cs_addr_i = '0;
  logic        cs_we_o;
  logic [11:0] cs_addr_o;
  logic [47:0] cs_wdata_o;
  logic        tpc_we_o;
  logic [2:0]  tpc_addr_o;
  logic [11:0] tpc_wdata_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk_i = ~clk_i;

  cs_loader u_cs_loader (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_sel_i(bus_sel_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .cs_addr_i(cs_addr_i), .cs_we_o(cs_we_o), .cs_addr_o(cs_addr_o),
    .cs_wdata_o(cs_wdata_o), .tpc_we_o(tpc_we_o), .tpc_addr_o(tpc_addr_o),
    .tpc_wdata_o(tpc_wdata_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one write; returns just after the capturing edge.
  task automatic bus_write(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_sel_i = sel; bus_wdata_i = data;
    @(posedge clk_i); #1;
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] sel, output logic [7:0] data);
    @(negedge clk_i);
    bus_rd_i = 1'b1; bus_sel_i = sel;
    @(posedge clk_i); #1;
    data = bus_rdata_o;
    bus_rd_i = 1'b0;
  endtask

  task automatic load_word(input logic [47:0] w, input logic [11:0] a, input string req);
    for (int k = 0; k < 6; k++) begin
      if (k == 5) cs_addr_i = a;
      bus_write(3'(k), ~w[47-8*k -: 8]);
      if (k < 5) check({req, " R3 no strobe before port 5"}, 64'(cs_we_o), 64'd0);
    end
    check({req, " R3 strobe"}, 64'(cs_we_o), 64'd1);
    check({req, " R2 word"}, 64'(cs_wdata_o), 64'(w));
    check({req, " R4 addr"}, 64'(cs_addr_o), 64'(a));
    @(posedge clk_i); #1;
    check({req, " R3 single pulse"}, 64'(cs_we_o), 64'd0);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    check("R1 cs_we", 64'(cs_we_o), 0);
    check("R1 tpc_we", 64'(tpc_we_o), 0);
    check("R1 cs_wdata", 64'(cs_wdata_o), 0);
    check("R1 tpc_wdata", 64'({tpc_addr_o, tpc_wdata_o}), 0);
    check("R1 rdata", 64'(bus_rdata_o), 0);
    bus_read(3'd0, r); check("R1 readback port0", 64'(r), 64'hFF);
    bus_read(3'd7, r); check("R1 readback port7", 64'(r), 64'h7F);
  endtask

  task automatic t_uword;
    load_word(48'h1234_5678_9ABC, 12'h3A5, "lanes");
    load_word(48'hFFFF_0000_A55A, 12'h000, "extremes");
  endtask

  task automatic t_partial;
    cs_addr_i = 12'hFFF;
    bus_write(3'd5, ~8'h3C);
    check("R5 retained upper bytes", 64'(cs_wdata_o), 64'h0000_FFFF_0000_A53C);
    check("R4 new addr", 64'(cs_addr_o), 64'hFFF);
  endtask

  task automatic t_tpc;
    bus_write(3'd6, 8'h4A);
    check("R6 high alone no strobe", 64'(tpc_we_o), 0);
    bus_write(3'd7, 8'hC3);
    check("R7 strobe", 64'(tpc_we_o), 1);
    check("R6 addr", 64'(tpc_addr_o), 64'd5);
    check("R7 data", 64'(tpc_wdata_o), 64'hABC);
    @(posedge clk_i); #1;
    check("R7 single pulse", 64'(tpc_we_o), 0);
    bus_write(3'd7, 8'h43);
    check("R7 bit7 ignored", 64'({tpc_addr_o, tpc_wdata_o}), 64'h5ABC);
    bus_write(3'd7, 8'h80);
    check("R8 reuse high", 64'({tpc_addr_o, tpc_wdata_o}), 64'h5AFF);
    bus_write(3'd6, 8'h00);
    check("R6 no strobe", 64'(tpc_we_o), 0);
    bus_write(3'd7, 8'h7F);
    check("R8 new high", 64'({tpc_addr_o, tpc_wdata_o}), 64'h7F80);
  endtask

  task automatic t_read;
    logic [7:0] r;
    bus_read(3'd0, r); check("R9 port0", 64'(r), 64'h00);
    check("R10 no strobe on read", 64'({cs_we_o, tpc_we_o}), 0);
    bus_read(3'd5, r); check("R9 port5", 64'(r), 64'hC3);
    bus_read(3'd6, r); check("R9 port6", 64'(r), 64'h00);
    bus_read(3'd7, r); check("R9 port7", 64'(r), 64'h7F);
    @(posedge clk_i); #1;
    check("R9 idle zero", 64'(bus_rdata_o), 0);
    cs_addr_i = 12'h123;
    bus_write(3'd5, 8'h00);
    check("R10 stage intact", 64'(cs_wdata_o), 64'h0000_FFFF_0000_A5FF);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_uword();
    t_partial();
    t_tpc();
    t_read();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule